// File: doc/BRIEF.md
# Stereo Audio Error Concealment Interpolator

This block sits after the error-correction stage of an audio playback path and hides samples that could not be repaired. Every incoming stereo sample carries one error flag per channel. Each channel keeps its own one-sample delay line, so the block holds a flagged sample until it has seen the sample that follows it. It then chooses an output value:

- An isolated flagged sample is replaced by the mean of its two neighbours.
- A run of flagged samples is covered by repeating the most recent good sample.
- When concealment is switched off, a flagged sample is passed through as it is.

A separate mute control zeroes both output channels. The delay history keeps advancing while mute is active.

Inputs arrive with a single-cycle valid strobe. Each strobe moves both channels forward by one sample, and one cycle later the block emits the previous sample on its output. The two control bits are sampled on the strobe that emits the output.

Top module: `conceal_top`

## Requirements
- R1: While reset is asserted, and after it until the first output, `out_valid` is 0 and both output samples are 0.
- R2: `out_valid` is high for exactly the one cycle that follows an accepted `in_valid` strobe. The first strobe after reset produces no output. Every later strobe emits the sample that arrived with the previous strobe.
- R3: With `mute` low, an unflagged sample (flag bit 0) appears at the output unchanged.
- R4: With `interp_en` low and `mute` low, a flagged sample (flag bit 1) appears at the output unchanged.
- R5: With `interp_en` high, a flagged sample whose preceding and following samples on the same channel are both unflagged is replaced by floor((prev + next) / 2). The sum is formed in two's complement with one extra bit, so it never wraps. Before the first sample after reset, the channel behaves as if it had seen a good sample of value 0.
- R6: With `interp_en` high, a flagged sample that has a flagged neighbour on either side is replaced by the most recent unflagged sample of that channel (0 if there has been none since reset).
- R7: When `mute` is high on the emitting strobe, both outputs are 0. The channel history, including the most recent good sample, still advances while muted.
- R8: Left and right channels decide independently, each from its own flags and samples.
- R9: `interp_en` and `mute` take effect on the strobe that emits the output, which is the strobe carrying the following sample.
- R10: Between strobes, the output samples hold their value and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| in_left | input | W | Left sample, two's complement |
| in_right | input | W | Right sample, two's complement |
| in_flag_left | input | 1 | 1 = left sample unreliable |
| in_flag_right | input | 1 | 1 = right sample unreliable |
| interp_en | input | 1 | 1 = conceal flagged samples |
| mute | input | 1 | 1 = force both outputs to zero |
| out_valid | output | 1 | One-cycle strobe marking a new output sample |
| out_left | output | W | Concealed left sample |
| out_right | output | W | Concealed right sample |

## Verification
Mute and concealment can both apply to the same emitting strobe. The bench drives random mute and enable patterns over flag sequences that contain isolated errors and runs, so a muted strobe often lands on a sample that would otherwise be averaged or held. Mute must win at the output. The held value that appears after mute is released must be a good sample that arrived while mute was active, which shows that the history kept advancing. Controls that change between a sample's arrival and its emission are checked against the emitting strobe's value.

// File: rtl/conceal_pkg.sv
package conceal_pkg;

  // Output source selected for the middle sample of a channel
  typedef enum logic [1:0] {
    PICK_PASS = 2'd0,
    PICK_MEAN = 2'd1,
    PICK_HOLD = 2'd2,
    PICK_ZERO = 2'd3
  } pick_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/conceal_mean.sv
module conceal_mean #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] mean_o
);

  localparam int SW = W + 1;

  logic signed [SW-1:0] sum;

  always_comb begin
    sum    = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    // drop LSB of the widened sum: arithmetic floor of the half
    mean_o = sum[SW-1:1];
  end

endmodule

// File: rtl/conceal_pick.sv
module conceal_pick
  import conceal_pkg::*;
(
  input  logic  mid_bad_i,
  input  logic  prev_bad_i,
  input  logic  next_bad_i,
  input  logic  interp_en_i,
  input  logic  mute_i,
  output pick_e pick_o
);

  always_comb begin
    if (mute_i) begin
      pick_o = PICK_ZERO;
    end else if (!mid_bad_i || !interp_en_i) begin
      pick_o = PICK_PASS;
    end else if (!prev_bad_i && !next_bad_i) begin
      pick_o = PICK_MEAN;
    end else begin
      pick_o = PICK_HOLD;
    end
  end

endmodule

// File: rtl/conceal_chan.sv
module conceal_chan
  import conceal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic         primed_i,
  input  logic [W-1:0] sample_i,
  input  logic         bad_i,
  input  logic         interp_en_i,
  input  logic         mute_i,
  output logic [W-1:0] sample_o
);

  logic [W-1:0] mid_q, mid_d;
  logic         mid_bad_q, mid_bad_d;
  logic         prev_bad_q, prev_bad_d;
  logic [W-1:0] good_q, good_d;
  logic [W-1:0] out_q, out_d;
  logic [W-1:0] mean_val;
  pick_e        pick;

  // previous sample equals good_q whenever prev_bad_q is clear
  conceal_mean #(.W(W)) u_mean (
    .a_i    (good_q),
    .b_i    (sample_i),
    .mean_o (mean_val)
  );

  conceal_pick u_pick (
    .mid_bad_i   (mid_bad_q),
    .prev_bad_i  (prev_bad_q),
    .next_bad_i  (bad_i),
    .interp_en_i (interp_en_i),
    .mute_i      (mute_i),
    .pick_o      (pick)
  );

  always_comb begin
    mid_d      = mid_q;
    mid_bad_d  = mid_bad_q;
    prev_bad_d = prev_bad_q;
    good_d     = good_q;
    out_d      = out_q;
    if (strobe_i) begin
      mid_d     = sample_i;
      mid_bad_d = bad_i;
      if (primed_i) begin
        prev_bad_d = mid_bad_q;
        if (!mid_bad_q) begin
          good_d = mid_q;
        end
        unique case (pick)
          PICK_PASS: out_d = mid_q;
          PICK_MEAN: out_d = mean_val;
          PICK_HOLD: out_d = good_q;
          PICK_ZERO: out_d = '0;
          default:   out_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q      <= '0;
      mid_bad_q  <= 1'b0;
      prev_bad_q <= 1'b0;
      good_q     <= '0;
      out_q      <= '0;
    end else begin
      mid_q      <= mid_d;
      mid_bad_q  <= mid_bad_d;
      prev_bad_q <= prev_bad_d;
      good_q     <= good_d;
      out_q      <= out_d;
    end
  end

  assign sample_o = out_q;

endmodule

// File: rtl/conceal_top.sv
module conceal_top
  import conceal_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic         in_flag_left,
  input  logic         in_flag_right,
  input  logic         interp_en,
  input  logic         mute,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);

  logic         primed_q, primed_d;
  logic         valid_q, valid_d;
  logic [W-1:0] ch_in  [NUM_CH];
  logic         ch_bad [NUM_CH];
  logic [W-1:0] ch_out [NUM_CH];

  assign ch_in[0]  = in_left;
  assign ch_in[1]  = in_right;
  assign ch_bad[0] = in_flag_left;
  assign ch_bad[1] = in_flag_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    conceal_chan #(.W(W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_i    (in_valid),
      .primed_i    (primed_q),
      .sample_i    (ch_in[c]),
      .bad_i       (ch_bad[c]),
      .interp_en_i (interp_en),
      .mute_i      (mute),
      .sample_o    (ch_out[c])
    );
  end

  always_comb begin
    primed_d = primed_q | in_valid;
    valid_d  = in_valid & primed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      primed_q <= primed_d;
      valid_q  <= valid_d;
    end
  end

  assign out_valid = valid_q;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

endmodule

// File: rtl/conceal_chk.sv
module conceal_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_left,
  input logic         in_flag_left,
  input logic         interp_en,
  input logic         mute,
  input logic         out_valid,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right
);

  logic         seen_q;
  logic [W-1:0] sh_left_q;
  logic         sh_flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      sh_left_q <= '0;
      sh_flag_q <= 1'b0;
    end else if (in_valid) begin
      seen_q    <= 1'b1;
      sh_left_q <= in_left;
      sh_flag_q <= in_flag_left;
    end
  end

  // R2
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R2
  first_strobe_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(seen_q));

  // R7
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mute)) |-> (out_left == '0 && out_right == '0));

  // R3
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(mute) && !$past(sh_flag_q)) |-> (out_left == $past(sh_left_q)));

  // R4
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(mute) && !$past(interp_en)) |-> (out_left == $past(sh_left_q)));

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_left) && $stable(out_right) && !out_valid));

endmodule

bind conceal_top conceal_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_left      (in_left),
  .in_flag_left (in_flag_left),
  .interp_en    (interp_en),
  .mute         (mute),
  .out_valid    (out_valid),
  .out_left     (out_left),
  .out_right    (out_right)
);

// File: tb/sim_conceal_top.sv
module sim_conceal_top;

  localparam int W      = 16;
  localparam int PERIOD = 10;
  localparam int MAXN   = 512;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_left, in_right;
  logic         in_flag_left, in_flag_right;
  logic         interp_en, mute;
  logic         out_valid;
  logic [W-1:0] out_left, out_right;

  int checks;
  int errors;
  int cycles;
  bit done;

  logic signed [W-1:0] smp [2][MAXN];
  bit                  flg [2][MAXN];
  bit                  en_a [MAXN];
  bit                  mu_a [MAXN];
  logic signed [W-1:0] good_m [2];
  int                  n;
  int unsigned         seed;

  conceal_top #(.W(W)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_left       (in_left),
    .in_right      (in_right),
    .in_flag_left  (in_flag_left),
    .in_flag_right (in_flag_right),
    .interp_en     (interp_en),
    .mute          (mute),
    .out_valid     (out_valid),
    .out_left      (out_left),
    .out_right     (out_right)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got %0d cycles exp < 200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int unsigned next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  // expected output of channel c for sample i, emitted on strobe k = i+1
  function automatic int model(input int c, input int k, output string tag);
    int i, pv, nv, s;
    bit f, pf, nf;
    i  = k - 1;
    f  = flg[c][i];
    pf = (i == 0) ? 1'b0 : flg[c][i-1];
    pv = (i == 0) ? 0 : int'(smp[c][i-1]);
    nf = flg[c][k];
    nv = int'(smp[c][k]);
    if (mu_a[k]) begin
      tag = "R7 mute";
      return 0;
    end
    if (!f) begin
      tag = "R3 clean";
      return int'(smp[c][i]);
    end
    if (!en_a[k]) begin
      tag = "R4 disabled";
      return int'(smp[c][i]);
    end
    if (!pf && !nf) begin
      tag = "R5 mean";
      s = pv + nv;
      return s >>> 1;
    end
    tag = "R6 hold";
    return int'(good_m[c]);
  endfunction

  task automatic push(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                      input bit fl, input bit fr, input bit en, input bit mu,
                      input int gap);
    string tg;
    int    e;
    logic [W-1:0] hl, hr;
    smp[0][n] = l;  smp[1][n] = r;
    flg[0][n] = fl; flg[1][n] = fr;
    en_a[n] = en;   mu_a[n] = mu;
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    in_flag_left = fl; in_flag_right = fr; interp_en = en; mute = mu;
    @(negedge clk);
    in_valid = 1'b0;
    in_left = $random; in_right = $random;
    in_flag_left = $random; in_flag_right = $random;
    if (n == 0) begin
      check("R2 first strobe silent", int'(out_valid), 0);
    end else begin
      check("R2 valid strobe", int'(out_valid), 1);
      e = model(0, n, tg);
      check({tg, " left R9"}, int'(signed'(out_left)), e);
      e = model(1, n, tg);
      check({tg, " right R8"}, int'(signed'(out_right)), e);
      for (int c = 0; c < 2; c++)
        if (!flg[c][n-1]) good_m[c] = smp[c][n-1];
    end
    n++;
    hl = out_left; hr = out_right;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R10 idle valid", int'(out_valid), 0);
      check("R10 idle hold", int'({out_left, out_right}), int'({hl, hr}));
    end
  endtask

  task automatic rand_push(input bit en, input bit mu, input int flag_rate);
    logic signed [W-1:0] l, r;
    int unsigned x;
    x = next_rand();
    l = W'(x >> 8);
    r = W'(next_rand() >> 5);
    if (x[3:0] == 4'd0) l = 16'sh7fff;
    if (x[3:0] == 4'd1) l = -16'sh8000;
    if (x[7:4] == 4'd2) r = -16'sh8000;
    push(l, r, (next_rand() % 100) < flag_rate, (next_rand() % 100) < flag_rate,
         en, mu, int'(next_rand() % 3));
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 1'b0; n = 0;
    seed = 32'h1234_5678;
    good_m[0] = '0; good_m[1] = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
    in_flag_left = 1'b0; in_flag_right = 1'b0; interp_en = 1'b0; mute = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 outputs in reset", int'({out_left, out_right}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outputs after reset", int'({out_valid, out_left, out_right}), 0);

    // start of stream: first sample flagged, zero-valued good predecessor (R5)
    push(16'sd0, 16'sd0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    push(16'sd100, -16'sd7, 1'b0, 1'b1, 1'b1, 1'b0, 1);
    // arithmetic corners for the mean (R5): no wrap, floor rounding
    push(16'sh7fff, 16'sh7fff, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    push(16'sd5, 16'sd5, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    push(16'sh7fff, -16'sh8000, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    push(16'sd1, 16'sd1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    push(-16'sh8000, -16'sh8000, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    push(16'sd9, 16'sd9, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    push(-16'sh8000, -16'sd3, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    // run of errors (R6) and enable toggling at emission (R9)
    push(16'sd300, 16'sd300, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    push(16'sd11, 16'sd12, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    push(16'sd13, 16'sd14, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    push(16'sd15, 16'sd16, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    push(-16'sd40, 16'sd40, 1'b0, 1'b0, 1'b1, 1'b0, 0);

    // concealment enabled, dense flags
    for (int k = 0; k < 120; k++) rand_push(1'b1, 1'b0, 40);
    // concealment disabled
    for (int k = 0; k < 60; k++) rand_push(1'b0, 1'b0, 50);
    // mute and enable randomised on each strobe (R7 with R5/R6)
    for (int k = 0; k < 200; k++) begin
      int unsigned x;
      x = next_rand();
      rand_push(x[9], x[12] & x[13], 35);
    end
    push(16'sd0, 16'sd0, 1'b0, 1'b0, 1'b1, 1'b0, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule